// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is the time base of a small microcontroller. The resonator clock passes through a divide-by-six prescaler, and the prescaler's enable drives a 10-bit up-counter. With a 6 MHz resonator the counter therefore advances once per microsecond. Software reads the low byte of the counter through a read-only I/O register at address 0x23.

Two taps on the counter produce periodic interrupt requests. The short request fires once every 128 counts. The long request fires once every 1024 counts, when the whole counter wraps. Both requests are single-cycle pulses, meant for an interrupt controller that lies outside this block.

Power-on reset clears the counter and the prescaler. A one-cycle strobe on suspend entry also clears both, so the timer restarts from a known phase when the part wakes. The read data output is zero whenever this block's register is not being read, so several blocks can OR their outputs onto one shared read bus.

Top module: `interval_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the counter, the prescaler, `io_rdata` and both interrupt outputs to zero.
- R2: The counter advances by one on every sixth clock edge. After reset is released, the 6th edge is the first one that takes the counter from 0 to 1.
- R3: When `io_rd` is high and `io_addr` equals 0x23 at a clock edge, `io_rdata` shows counter bits 7..0 in the following cycle.
- R4: When `io_rd` is low, or `io_addr` differs from 0x23, at a clock edge, `io_rdata` is 0x00 in the following cycle.
- R5: A read that is sampled on the same edge as an increment returns the counter value from before that increment.
- R6: `irq_short` is high for exactly one cycle each time counter bits 6..0 wrap from 0x7F to 0x00, which happens once every 128 counts. It is low at all other times.
- R7: `irq_long` is high for exactly one cycle when the full 10-bit counter wraps from 0x3FF to 0x000. `irq_short` is high in that same cycle.
- R8: A high `susp_enter` at a clock edge clears the counter and the prescaler. This takes priority over any increment due on that edge, and no interrupt is raised for it. The next increment then comes on the 6th edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Resonator clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| susp_enter | input | 1 | One-cycle strobe on suspend entry; clears the timer |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O read address |
| io_rdata | output | 8 | Registered read data; zero unless address 0x23 was read |
| irq_short | output | 1 | One-cycle pulse every 128 counts |
| irq_long | output | 1 | One-cycle pulse every 1024 counts |

## Verification
The bench times the first increment after reset and after a suspend strobe. A prescaler that divides by five or seven, or that does not restart its phase on suspend, misses those edges. It reads the counter on the exact edge where an increment is due. A design that forwards the incremented value fails that check. The bench also follows the counter through a full 1024-count wrap, counting short pulses and checking that the long pulse lands with a short pulse in the same cycle. A wrong tap width or a long pulse that is one count late shows up there. Random reads to nearby addresses catch decoders that leak data onto the shared bus. Rare random suspend strobes catch a clear that loses to a pending increment.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
// timer_pkg: shared constants of the prescaled interval timer.
// Assumes: the consumers take these as parameter defaults only.
package timer_pkg;
    localparam int unsigned TMR_DIV        = 6;      // resonator clocks per count
    localparam int unsigned TMR_CNT_W      = 10;     // main counter width
    localparam int unsigned TMR_SHORT_SPAN = 7;      // low bits that wrap for the short interrupt
    localparam int unsigned TMR_ADDR_W     = 8;      // I/O address width
    localparam int unsigned TMR_DATA_W     = 8;      // I/O data width
    localparam logic [7:0]  TMR_RD_ADDR    = 8'h23;  // address of the readable count byte
endpackage

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
// timer_prescaler: modulo-DIV phase counter that issues a one-cycle enable
// on its last phase.
// Assumes: DIV >= 2; clr has the same effect as reset.
module timer_prescaler #(
    parameter int unsigned DIV = timer_pkg::TMR_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    // Enable on the final phase of each period.
    assign tick = (phase_q == LAST);

    // Phase counter, wraps after the final phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
// timer_counter: free-running binary up-counter that advances on the
// prescaler enable.
// Assumes: clr takes priority over tick.
module timer_counter #(
    parameter int unsigned W = timer_pkg::TMR_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    // Count register; wraps naturally at 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/timer_tap.sv
`timescale 1ns/1ps
// timer_tap: registers a one-cycle pulse when the low SPAN bits of the
// counter roll over from all ones to zero.
// Assumes: low_bits is the current (pre-increment) counter slice.
module timer_tap #(
    parameter int unsigned SPAN = timer_pkg::TMR_SHORT_SPAN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  logic [SPAN-1:0] low_bits,
    output logic            pulse
);
    logic pulse_q;

    // Pulse in the cycle in which the slice has just become zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick && (&low_bits);
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/timer_rdport.sv
`timescale 1ns/1ps
// timer_rdport: read-only I/O register. It returns the value on a hit and
// zero otherwise, so that outputs can be OR-combined on a shared bus.
// Assumes: value is sampled on the same edge as any increment.
module timer_rdport #(
    parameter int unsigned  AW   = timer_pkg::TMR_ADDR_W,
    parameter int unsigned  DW   = timer_pkg::TMR_DATA_W,
    parameter logic [AW-1:0] ADDR = AW'(timer_pkg::TMR_RD_ADDR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] value,
    output logic [DW-1:0] rdata
);
    logic          hit;
    logic [DW-1:0] rdata_q;

    // Address decode for the count byte.
    assign hit = rd && (addr == ADDR);

    // Registered read data, zero when not selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= hit ? value : '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
// interval_timer: divide-by-DIV prescaler feeding a CNT_W-bit counter.
// It has a read-only byte register and two rollover interrupt taps.
// Assumes: susp_enter is a one-cycle strobe; rst_n is synchronous.
module interval_timer #(
    parameter int unsigned   DIV        = timer_pkg::TMR_DIV,
    parameter int unsigned   CNT_W      = timer_pkg::TMR_CNT_W,
    parameter int unsigned   SHORT_SPAN = timer_pkg::TMR_SHORT_SPAN,
    parameter int unsigned   AW         = timer_pkg::TMR_ADDR_W,
    parameter int unsigned   DW         = timer_pkg::TMR_DATA_W,
    parameter logic [AW-1:0] RD_ADDR    = AW'(timer_pkg::TMR_RD_ADDR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          susp_enter,
    input  logic          io_rd,
    input  logic [AW-1:0] io_addr,
    output logic [DW-1:0] io_rdata,
    output logic          irq_short,
    output logic          irq_long
);
    localparam int unsigned N_TAPS = 2;

    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [N_TAPS-1:0] irq_vec;

    timer_prescaler #(.DIV(DIV)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (susp_enter),
        .tick  (tick)
    );

    timer_counter #(.W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (susp_enter),
        .tick  (tick),
        .cnt   (cnt_q)
    );

    // One tap per interval: index 0 is the short span, index 1 the full width.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned SPAN = (g == 0) ? SHORT_SPAN : CNT_W;
        timer_tap #(.SPAN(SPAN)) i_tap (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (susp_enter),
            .tick     (tick),
            .low_bits (cnt_q[SPAN-1:0]),
            .pulse    (irq_vec[g])
        );
    end

    assign irq_short = irq_vec[0];
    assign irq_long  = irq_vec[1];

    timer_rdport #(.AW(AW), .DW(DW), .ADDR(RD_ADDR)) i_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (io_rd),
        .addr  (io_addr),
        .value (cnt_q[DW-1:0]),
        .rdata (io_rdata)
    );
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
// timer_checker: temporal properties of interval_timer, attached by bind.
// Assumes: bound inside interval_timer so tick and cnt_q are visible.
module timer_checker #(
    parameter int unsigned   CNT_W      = 10,
    parameter int unsigned   SHORT_SPAN = 7,
    parameter int unsigned   AW         = 8,
    parameter int unsigned   DW         = 8,
    parameter logic [AW-1:0] RD_ADDR    = 8'h23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             susp_enter,
    input logic             io_rd,
    input logic [AW-1:0]    io_addr,
    input logic [DW-1:0]    io_rdata,
    input logic             irq_short,
    input logic             irq_long,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q
);
    AST_TICK_SPACED:  assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2
    AST_COUNT_STEP:   assert property (@(posedge clk) disable iff (!rst_n) (tick && !susp_enter) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
    AST_COUNT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!tick && !susp_enter) |=> $stable(cnt_q)); // R2
    AST_READ_VALUE:   assert property (@(posedge clk) disable iff (!rst_n) (io_rd && io_addr == RD_ADDR) |=> (io_rdata == $past(cnt_q[DW-1:0]))); // R5
    AST_READ_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !(io_rd && io_addr == RD_ADDR) |=> (io_rdata == '0)); // R4
    AST_SHORT_ALIGN:  assert property (@(posedge clk) disable iff (!rst_n) irq_short |-> (cnt_q[SHORT_SPAN-1:0] == '0)); // R6
    AST_SHORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_short |=> !irq_short); // R6
    AST_LONG_BOTH:    assert property (@(posedge clk) disable iff (!rst_n) irq_long |-> (irq_short && cnt_q == '0)); // R7
    AST_SUSP_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) susp_enter |=> (cnt_q == '0 && !irq_short && !irq_long)); // R8
endmodule

bind interval_timer timer_checker #(
    .CNT_W(CNT_W), .SHORT_SPAN(SHORT_SPAN), .AW(AW), .DW(DW), .RD_ADDR(RD_ADDR)
) i_timer_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .susp_enter (susp_enter),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_rdata   (io_rdata),
    .irq_short  (irq_short),
    .irq_long   (irq_long),
    .tick       (tick),
    .cnt_q      (cnt_q)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
// test_interval_timer: directed corner cases plus seeded random traffic,
// compared against a cycle model built from the requirements.
module test_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       susp_enter;
    logic       io_rd;
    logic [7:0] io_addr;
    logic [7:0] io_rdata;
    logic       irq_short;
    logic       irq_long;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst_n(rst_n), .susp_enter(susp_enter), .io_rd(io_rd),
        .io_addr(io_addr), .io_rdata(io_rdata), .irq_short(irq_short), .irq_long(irq_long)
    );

    // Requirement model state
    int         m_phase;
    logic [9:0] m_cnt;
    logic [7:0] m_rd;
    logic       m_hit, m_is, m_il;

    function automatic logic [7:0] exp_read(logic rd, logic [7:0] addr, logic [9:0] cnt);
        return (rd && addr == 8'h23) ? cnt[7:0] : 8'h00;
    endfunction

    function automatic logic short_wrap(logic [9:0] cnt);
        return cnt[6:0] == 7'h7F;
    endfunction

    always @(posedge clk) begin
        m_rd  <= rst_n ? exp_read(io_rd, io_addr, m_cnt) : 8'h00;
        m_hit <= io_rd && io_addr == 8'h23;
        if (!rst_n || susp_enter) begin
            m_phase <= 0; m_cnt <= '0; m_is <= 1'b0; m_il <= 1'b0;
        end else begin
            m_phase <= (m_phase == 5) ? 0 : m_phase + 1;
            m_cnt   <= (m_phase == 5) ? m_cnt + 10'd1 : m_cnt;
            m_is    <= (m_phase == 5) && short_wrap(m_cnt);
            m_il    <= (m_phase == 5) && (m_cnt == 10'h3FF);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(io_rdata == m_rd, m_hit ? "R3" : "R4", io_rdata, m_rd);
        check(irq_short == m_is, "R6", irq_short, m_is);
        check(irq_long == m_il, "R7", irq_long, m_il);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int shorts, longs, both;
        void'($urandom(32'd20240917));
        rst_n = 1'b0; susp_enter = 1'b0; io_rd = 1'b1; io_addr = 8'h23;
        repeat (3) step();
        // R1: reset state
        check(io_rdata == 8'h00 && !irq_short && !irq_long, "R1",
              {io_rdata, irq_short, irq_long}, 0);

        // R2 / R5: first increment is on the 6th edge after release
        @(negedge clk); rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            step();
            if (k == 6) check(io_rdata == 8'd0, "R5", io_rdata, 0);
            else        check(io_rdata == 8'((k - 1) / 6), "R2", io_rdata, (k - 1) / 6);
        end

        // R4: wrong address, then no strobe
        io_addr = 8'h22; step();
        check(io_rdata == 8'h00, "R4", io_rdata, 0);
        io_rd = 1'b0; io_addr = 8'h23; step();
        check(io_rdata == 8'h00, "R4", io_rdata, 0);

        // R6 / R7: run through a full wrap, counting pulses
        shorts = 0; longs = 0; both = 0;
        for (int i = 0; i < 7000 && longs == 0; i++) begin
            step();
            if (irq_short) shorts++;
            if (irq_long) begin longs++; if (irq_short) both++; end
        end
        check(shorts == 8, "R6", shorts, 8);
        check(longs == 1 && both == 1, "R7", {longs[7:0], both[7:0]}, 16'h0101);

        // R8: suspend clears and restarts the prescaler phase
        repeat (40) step();
        susp_enter = 1'b1; step();
        susp_enter = 1'b0; io_rd = 1'b1; io_addr = 8'h23;
        for (int k = 1; k <= 7; k++) begin
            step();
            if (k == 1) check(io_rdata == 8'd0, "R8", io_rdata, 0);
            if (k == 6) check(io_rdata == 8'd0, "R8", io_rdata, 0);
            if (k == 7) check(io_rdata == 8'd1, "R8", io_rdata, 1);
        end

        // Random traffic against the model
        for (int i = 0; i < 25000; i++) begin
            io_rd      = $urandom_range(0, 1) == 1;
            io_addr    = ($urandom_range(0, 1) == 1) ? 8'h23 : 8'($urandom_range(0, 255));
            susp_enter = $urandom_range(0, 2999) == 0;
            step();
        end
        susp_enter = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule